// File: doc/BRIEF.md
# Dual-Register Keystream Generator Core

This block is a synchronous keystream generator for a lightweight stream cipher. Its state is two 80-bit shift registers. The first has linear feedback from a primitive polynomial. The second has nonlinear feedback, and its input is masked by the oldest bit of the linear register. A sparse five-input Boolean filter reads taps from both registers. Each keystream bit is that filter's output XORed with the oldest bit of the nonlinear register.

A one-cycle load strobe captures an 80-bit key and a 64-bit IV. The core then spends 160 steps mixing its state and shows `busy_o` while it does so. During this phase the filter output is folded into the feedback of both registers. After mixing, the core raises `ks_valid_o` and produces `STEPS` keystream bits on every clock.

`STEPS` is a compile-time parameter (1, 2, 4, 8 or 16). It replicates the step logic so that each register moves `STEPS` places per clock. Register positions 65 to 79 are never tapped, which is what makes this unrolling cheap. A new load strobe in any state discards the current stream and starts mixing again.

Top module: `ks_core`

## Requirements
- R1: In every step the linear register shifts toward position 0, and its new top bit (position 79) is the XOR of positions 0, 13, 23, 38, 51 and 62.
- R2: In every step the nonlinear register shifts toward position 0. Its new top bit is linear-register position 0 XOR the nonlinear polynomial. That polynomial uses linear taps 0, 9, 15, 21, 28, 33, 37, 45, 52, 60 and 63, plus the eleven fixed product terms of the update function.
- R3: Each keystream bit equals h XOR nonlinear position 0, taken from the state before the step. The filter is h = x1^x4^x0x3^x2x3^x3x4^x0x1x2^x0x2x3^x0x2x4^x1x2x4^x2x3x4, with x0..x3 = linear positions 3, 25, 46, 64 and x4 = nonlinear position 63.
- R4: On a load, nonlinear position j takes `key_i[j]` and linear position j takes `iv_i[j]` for j < 64. Linear positions 64..79 are set to 1.
- R5: After a load, `busy_o` is high for exactly 160/STEPS clocks. `ks_valid_o` rises on the clock that follows the last of them.
- R6: While busy, h is XORed into the new top bit of both registers in every step. In the output phase it is not.
- R7: While valid, each clock delivers STEPS bits, with `ks_o[0]` the earliest in time, and advances the state by STEPS steps.
- R8: A load strobe in the idle, mixing or output state discards the current state and restarts with a full mixing phase on the new key and IV.
- R9: While `rst_n` is low, and afterwards until a load, `busy_o` and `ks_valid_o` are low and `ks_o` is zero. `ks_o` is zero whenever `ks_valid_o` is low.
- R10: `busy_o` and `ks_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | One-cycle strobe that captures key and IV and starts mixing |
| key_i | input | 80 | Key; bit j goes to nonlinear position j |
| iv_i | input | 64 | IV; bit j goes to linear position j |
| busy_o | output | 1 | High during the mixing phase |
| ks_valid_o | output | 1 | High while `ks_o` carries keystream |
| ks_o | output | STEPS | Keystream bits; bit 0 is the earliest |

## Verification
The hardest case to reach from the ports is a single-bit difference in key or IV. Because of the long mixing phase, its effect shows up only in keystream that looks random. The bench therefore sweeps every single-bit key and every single-bit IV. For each one, it compares several output words against a bit-serial model that it steps one position at a time. A wrong tap, a wrong product term or a missing filter injection then changes at least one compared word. The bench also fires load strobes part-way through mixing and part-way through output, and asserts reset mid-stream, to reach the abort paths.

// File: rtl/ks_core_pkg.sv
package ks_core_pkg;

  localparam int REG_W      = 80;
  localparam int IV_W       = 64;
  localparam int MIX_STEPS  = 160;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MIX  = 2'd1,
    ST_OUT  = 2'd2
  } ks_state_e;

  // Linear recurrence: new top bit of the linear register
  function automatic logic lin_fb(input logic [REG_W-1:0] s);
    return s[62] ^ s[51] ^ s[38] ^ s[23] ^ s[13] ^ s[0];
  endfunction

  // Nonlinear polynomial over the nonlinear register alone
  function automatic logic nl_fb(input logic [REG_W-1:0] b);
    logic lin_part;
    logic prod_part;
    lin_part  = b[63] ^ b[60] ^ b[52] ^ b[45] ^ b[37] ^ b[33] ^
                b[28] ^ b[21] ^ b[15] ^ b[9]  ^ b[0];
    prod_part = (b[63] & b[60]) ^ (b[37] & b[33]) ^ (b[15] & b[9]) ^
                (b[60] & b[52] & b[45]) ^ (b[33] & b[28] & b[21]) ^
                (b[63] & b[45] & b[28] & b[9]) ^
                (b[60] & b[52] & b[37] & b[33]) ^
                (b[63] & b[60] & b[21] & b[15]) ^
                (b[63] & b[60] & b[52] & b[45] & b[37]) ^
                (b[33] & b[28] & b[21] & b[15] & b[9]) ^
                (b[52] & b[45] & b[37] & b[33] & b[28] & b[21]);
    return lin_part ^ prod_part;
  endfunction

  // Five-input output filter
  function automatic logic filt(input logic [REG_W-1:0] s,
                                input logic [REG_W-1:0] b);
    logic x0, x1, x2, x3, x4;
    x0 = s[3];
    x1 = s[25];
    x2 = s[46];
    x3 = s[64];
    x4 = b[63];
    return x1 ^ x4 ^ (x0 & x3) ^ (x2 & x3) ^ (x3 & x4) ^
           (x0 & x1 & x2) ^ (x0 & x2 & x3) ^ (x0 & x2 & x4) ^
           (x1 & x2 & x4) ^ (x2 & x3 & x4);
  endfunction

endpackage

// File: rtl/ks_step.sv
module ks_step
  import ks_core_pkg::*;
(
  input  logic [REG_W-1:0] s_i,
  input  logic [REG_W-1:0] b_i,
  input  logic             mix_i,
  output logic [REG_W-1:0] s_o,
  output logic [REG_W-1:0] b_o,
  output logic             z_o
);

  logic h_w;
  logic inj_w;

  always_comb begin
    h_w   = filt(s_i, b_i);
    inj_w = mix_i & h_w;
    z_o   = h_w ^ b_i[0];
    s_o   = {lin_fb(s_i) ^ inj_w, s_i[REG_W-1:1]};
    b_o   = {nl_fb(b_i) ^ s_i[0] ^ inj_w, b_i[REG_W-1:1]};
  end

endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import ks_core_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic step_en_o,
  output logic mix_o,
  output logic busy_o,
  output logic valid_o
);

  localparam int MIX_CLKS = MIX_STEPS / STEPS;
  localparam int CW       = (MIX_CLKS > 1) ? $clog2(MIX_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MIX_CLKS - 1);

  ks_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (load_i) begin
      state_d = ST_MIX;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        ST_MIX: begin
          cnt_en = 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = ST_OUT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_OUT:  state_d = ST_OUT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o    = (state_q == ST_MIX);
  assign valid_o   = (state_q == ST_OUT);
  assign mix_o     = busy_o;
  assign step_en_o = (state_q != ST_IDLE) && !load_i;

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && valid_o));

  p_out_after_mix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(busy_o) && $past(cnt_q) == CNT_LAST);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cnt_q <= CNT_LAST);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> busy_o && cnt_q == '0);

endmodule

// File: rtl/ks_datapath.sv
module ks_datapath
  import ks_core_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] key_i,
  input  logic [IV_W-1:0]  iv_i,
  input  logic             step_en_i,
  input  logic             mix_i,
  input  logic             valid_i,
  output logic [STEPS-1:0] ks_o
);

  localparam int PAD_W = REG_W - IV_W;

  logic [REG_W-1:0] lfsr_q, lfsr_d;
  logic [REG_W-1:0] nfsr_q, nfsr_d;
  logic             reg_en;
  logic [REG_W-1:0] s_ch [STEPS+1];
  logic [REG_W-1:0] b_ch [STEPS+1];
  logic [STEPS-1:0] z_w;

  assign s_ch[0] = lfsr_q;
  assign b_ch[0] = nfsr_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    ks_step u_step (
      .s_i   (s_ch[g]),
      .b_i   (b_ch[g]),
      .mix_i (mix_i),
      .s_o   (s_ch[g+1]),
      .b_o   (b_ch[g+1]),
      .z_o   (z_w[g])
    );
  end

  always_comb begin
    lfsr_d = lfsr_q;
    nfsr_d = nfsr_q;
    reg_en = load_i | step_en_i;
    if (load_i) begin
      nfsr_d = key_i;
      lfsr_d = {{PAD_W{1'b1}}, iv_i};
    end else if (step_en_i) begin
      lfsr_d = s_ch[STEPS];
      nfsr_d = b_ch[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '0;
      nfsr_q <= '0;
    end else if (reg_en) begin
      lfsr_q <= lfsr_d;
      nfsr_q <= nfsr_d;
    end
  end

  assign ks_o = valid_i ? z_w : '0;

  p_lfsr_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_en_i) && !$past(load_i) |->
      lfsr_q[REG_W-1-STEPS:0] == $past(lfsr_q[REG_W-1:STEPS]));

  p_nfsr_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_en_i) && !$past(load_i) |->
      nfsr_q[REG_W-1-STEPS:0] == $past(nfsr_q[REG_W-1:STEPS]));

  p_load_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> lfsr_q[REG_W-1:IV_W] == {PAD_W{1'b1}}
                      && nfsr_q == $past(key_i)
                      && lfsr_q[IV_W-1:0] == $past(iv_i));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> ks_o == '0);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) && !$past(step_en_i) |-> $stable(lfsr_q) && $stable(nfsr_q));

endmodule

// File: rtl/ks_core.sv
module ks_core
  import ks_core_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [79:0]      key_i,
  input  logic [63:0]      iv_i,
  output logic             busy_o,
  output logic             ks_valid_o,
  output logic [STEPS-1:0] ks_o
);

  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       step_en;
  logic       mix;
  logic       busy;
  logic       valid;

  // Reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  ks_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_i    (load_i),
    .step_en_o (step_en),
    .mix_o     (mix),
    .busy_o    (busy),
    .valid_o   (valid)
  );

  ks_datapath #(.STEPS(STEPS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_i    (load_i),
    .key_i     (key_i),
    .iv_i      (iv_i),
    .step_en_i (step_en),
    .mix_i     (mix),
    .valid_i   (valid),
    .ks_o      (ks_o)
  );

  assign busy_o     = busy;
  assign ks_valid_o = valid;

endmodule

// File: tb/sim_ks_core.sv
module sim_ks_core;

  localparam int PERIOD   = 10;
  localparam int STEPS    = 4;
  localparam int MIX_CLKS = 160 / STEPS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_i;
  logic [79:0]      key_i;
  logic [63:0]      iv_i;
  logic             busy_o;
  logic             ks_valid_o;
  logic [STEPS-1:0] ks_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int overlap = 0;

  logic [79:0] m_s, m_b;
  logic [63:0] rnd = 64'h9E3779B97F4A7C15;

  ks_core #(.STEPS(STEPS)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .iv_i(iv_i),
    .busy_o(busy_o), .ks_valid_o(ks_valid_o), .ks_o(ks_o)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) if (busy_o && ks_valid_o) overlap++;

  // Bit-serial reference model, one position per call
  task automatic model_one(input bit mix, output bit z);
    bit h, fl, fn, x0, x1, x2, x3, x4;
    x0 = m_s[3]; x1 = m_s[25]; x2 = m_s[46]; x3 = m_s[64]; x4 = m_b[63];
    h = x1 ^ x4 ^ (x0&x3) ^ (x2&x3) ^ (x3&x4) ^ (x0&x1&x2) ^ (x0&x2&x3)
        ^ (x0&x2&x4) ^ (x1&x2&x4) ^ (x2&x3&x4);
    z = h ^ m_b[0];
    fl = m_s[0] ^ m_s[13] ^ m_s[23] ^ m_s[38] ^ m_s[51] ^ m_s[62];
    fn = m_s[0] ^ m_b[0] ^ m_b[9] ^ m_b[15] ^ m_b[21] ^ m_b[28] ^ m_b[33]
         ^ m_b[37] ^ m_b[45] ^ m_b[52] ^ m_b[60] ^ m_b[63]
         ^ (m_b[60]&m_b[63]) ^ (m_b[33]&m_b[37]) ^ (m_b[9]&m_b[15])
         ^ (m_b[45]&m_b[52]&m_b[60]) ^ (m_b[21]&m_b[28]&m_b[33])
         ^ (m_b[9]&m_b[28]&m_b[45]&m_b[63]) ^ (m_b[33]&m_b[37]&m_b[52]&m_b[60])
         ^ (m_b[15]&m_b[21]&m_b[60]&m_b[63])
         ^ (m_b[37]&m_b[45]&m_b[52]&m_b[60]&m_b[63])
         ^ (m_b[9]&m_b[15]&m_b[21]&m_b[28]&m_b[33])
         ^ (m_b[21]&m_b[28]&m_b[33]&m_b[37]&m_b[45]&m_b[52]);
    if (mix) begin fl ^= h; fn ^= h; end
    m_s = {fl, m_s[79:1]};
    m_b = {fn, m_b[79:1]};
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic strobe_load(input logic [79:0] k, input logic [63:0] v);
    @(negedge clk);
    load_i = 1'b1; key_i = k; iv_i = v;
    m_b = k; m_s = {16'hFFFF, v};
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // Load, verify mixing length, then compare nw output words
  task automatic run_case(input logic [79:0] k, input logic [63:0] v,
                          input int nw, input string tag);
    int bc = 0;
    int bad = 0;
    logic [STEPS-1:0] exp, act_first, exp_first;
    bit z;
    act_first = '0; exp_first = '0;
    strobe_load(k, v);
    for (int c = 0; c < MIX_CLKS; c++) begin
      if (busy_o && !ks_valid_o) bc++;
      for (int j = 0; j < STEPS; j++) model_one(1'b1, z);
      @(negedge clk);
    end
    // R5: busy for exactly MIX_CLKS clocks, then valid
    check(bc == MIX_CLKS && ks_valid_o && !busy_o, "R5", {tag, " mix length"},
          80'(bc), 80'(MIX_CLKS));
    for (int w = 0; w < nw; w++) begin
      for (int j = 0; j < STEPS; j++) begin
        model_one(1'b0, z);
        exp[j] = z;
      end
      if (ks_o !== exp || !ks_valid_o) begin
        if (bad == 0) begin act_first = ks_o; exp_first = exp; end
        bad++;
      end
      @(negedge clk);
    end
    // R1 R2 R3 R6 R7: stream matches serial model
    check(bad == 0, "R3", {tag, " keystream"}, 80'(act_first), 80'(exp_first));
  endtask

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; key_i = '0; iv_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy_o && !ks_valid_o && ks_o == '0, "R9", "in reset",
          {busy_o, ks_valid_o, 78'(ks_o)}, 80'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!busy_o && !ks_valid_o && ks_o == '0, "R9", "idle without load",
          {busy_o, ks_valid_o, 78'(ks_o)}, 80'd0);

    run_case(80'd0, 64'd0, 20, "R4 zero");
    run_case({20{4'h4}}, {16{4'h5}}, 20, "R4 fourfive");
    run_case({20{4'hA}}, {16{4'hB}}, 20, "R4 ab");
    run_case({80{1'b1}}, {64{1'b1}}, 20, "R6 ones");
    for (int r = 0; r < 6; r++) begin
      logic [79:0] k;
      rnd = xs(rnd); k[63:0] = rnd;
      rnd = xs(rnd); k[79:64] = rnd[15:0];
      rnd = xs(rnd);
      run_case(k, rnd, 10, "R7 random");
    end
    // R1 R2 sweep: every single key bit
    for (int j = 0; j < 80; j++) run_case(80'd1 << j, 64'd0, 6, "R2 keybit");
    // R1 sweep: every single IV bit
    for (int j = 0; j < 64; j++) run_case(80'd0, 64'd1 << j, 6, "R1 ivbit");

    // R8: load in the middle of mixing
    strobe_load({20{4'h3}}, {16{4'hC}});
    repeat (7) @(negedge clk);
    check(busy_o, "R8", "busy before abort", 80'(busy_o), 80'd1);
    run_case({20{4'h6}}, {16{4'h9}}, 12, "R8 abort mix");

    // R8: load in the middle of output (stream already valid)
    check(ks_valid_o, "R8", "valid before abort", 80'(ks_valid_o), 80'd1);
    run_case({20{4'hE}}, {16{4'h1}}, 12, "R8 abort out");

    // R9: reset mid-stream clears outputs
    #(PERIOD/4) rst_n = 1'b0;
    #1;
    check(!busy_o && !ks_valid_o && ks_o == '0, "R9", "async reset mid-stream",
          {busy_o, ks_valid_o, 78'(ks_o)}, 80'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !ks_valid_o, "R9", "idle after reset",
          {busy_o, ks_valid_o, 78'd0}, 80'd0);
    run_case(80'd0, 64'd0, 8, "R9 after reset");

    // R10: never busy and valid together
    check(overlap == 0, "R10", "busy/valid overlap", 80'(overlap), 80'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule